// File: doc/BRIEF.md
# UART Transmit Status with Programmable Holding-Empty Mode

This block keeps the transmit-side status of a 16550-style serial port. It does not move data bits. It counts how many characters wait in the transmit holding stage. That stage is a single holding register when the FIFO is off and a 16-entry FIFO when it is on. The block also tracks whether the transmit shift register is busy. From these two pieces of state it produces a holding-empty flag, a transmitter-empty flag and a transmit interrupt request.

In normal operation the holding-empty flag means "nothing waits to be sent", and the interrupt follows that flag. When the alternate mode is enabled and the FIFO is on, the meaning of the flag changes to "FIFO full". This lets software keep writing until the flag rises. In this mode the interrupt no longer follows the flag. It comes from a comparator that checks the FIFO level against a threshold selected by two bits. The surrounding logic supplies the events: a host write, a shift-register load and a shift-complete pulse.

All three outputs are registered. Each output shows the state produced by the inputs sampled at the previous rising clock edge.

Top module: `uart_tx_status`

## Requirements
- R1: While `rst` is high at a rising edge, the edge leaves `hold_empty`=1, `tx_empty`=1 and `tx_irq`=0, with the occupancy at zero and the shift register idle.
- R2: The occupancy capacity is 16 when `fifo_on`=1 and 1 when `fifo_on`=0. A `wr_stb` adds one character only while the occupancy is below the capacity. A write to a full holding stage is ignored and leaves every output unchanged.
- R3: An `sr_load` moves one character from the holding stage into the shift register. This happens only when the occupancy is nonzero and the shift register is idle or finishing (`sr_done` high in the same cycle). Otherwise the load is ignored. `sr_done` without an accepted load makes the shift register idle.
- R4: `tx_empty` is 1 exactly when the occupancy is zero and the shift register is idle.
- R5: With the alternate mode inactive (`alt_mode`=0 or `fifo_on`=0), `hold_empty` is 1 exactly when the occupancy is zero.
- R6: With `alt_mode`=1 and `fifo_on`=1, `hold_empty` is 1 exactly when the occupancy equals 16 (FIFO full).
- R7: With the alternate mode inactive, `tx_irq` equals `irq_en` AND `hold_empty`.
- R8: With the alternate mode active, `tx_irq` equals `irq_en` AND (occupancy <= limit). The limit is set by `thr_sel`: 2'b00 gives 0, 2'b01 gives 2, 2'b10 gives 4 (a quarter) and 2'b11 gives 8 (half).
- R9: In a cycle where `fifo_on` differs from its value at the previous edge, the holding stage is flushed to zero occupancy and that cycle's write and load are ignored. The reference value after reset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Host writes one character to the holding stage |
| sr_load | input | 1 | Request to move one character into the shift register |
| sr_done | input | 1 | Shift register finished sending its character |
| fifo_on | input | 1 | 1 selects the 16-entry FIFO, 0 the single holding register |
| alt_mode | input | 1 | Enables the alternate full-flag and threshold-interrupt mode |
| irq_en | input | 1 | Transmit interrupt enable |
| thr_sel | input | 2 | Threshold select for the alternate interrupt |
| hold_empty | output | 1 | Holding-empty flag, or FIFO-full flag in the alternate mode |
| tx_empty | output | 1 | Holding stage and shift register both empty |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
A wrong occupancy count shows up at the ports in the first cycle it matters. In normal mode an occupancy that is off by one makes `hold_empty` or `tx_empty` wrong at the edge where the true count reaches zero. In the alternate mode the same error shifts the full flag and the threshold crossings by one entry, and a sweep over all four threshold codes exposes it within one fill and drain. A shift-busy flag that is stuck or lost makes `tx_empty` wrong and makes a later load get accepted or refused wrongly, one cycle after the bad event. The bench compares all three outputs against a cycle model after every edge, so any divergence is reported in the cycle it appears.

// File: rtl/uart_txs_pkg.sv
package uart_txs_pkg;
  // threshold select codes for the alternate-mode interrupt
  typedef enum logic [1:0] {
    THR_EMPTY   = 2'b00,
    THR_TWO     = 2'b01,
    THR_QUARTER = 2'b10,
    THR_HALF    = 2'b11
  } thr_sel_e;
endpackage

// File: rtl/txs_occupancy.sv
module txs_occupancy #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic          sr_load,
  input  logic          sr_done,
  input  logic          fifo_on,
  output logic [CW-1:0] cnt_nx,
  output logic          busy_nx
);
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          fifo_on_q;
  logic [CW-1:0] cap;
  logic          flush, wr_ok, ld_ok;

  assign flush = fifo_on ^ fifo_on_q;
  assign cap   = fifo_on ? CW'(DEPTH) : CW'(1);
  assign wr_ok = !flush && wr_stb && (cnt_q < cap);
  assign ld_ok = !flush && sr_load && (cnt_q != '0) && (!busy_q || sr_done);

  always_comb begin
    cnt_nx = cnt_q;
    if (flush) begin
      cnt_nx = '0;
    end else begin
      case ({wr_ok, ld_ok})
        2'b10:   cnt_nx = cnt_q + CW'(1);
        2'b01:   cnt_nx = cnt_q - CW'(1);
        default: cnt_nx = cnt_q;
      endcase
    end
  end

  assign busy_nx = ld_ok ? 1'b1 : (sr_done ? 1'b0 : busy_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      fifo_on_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_nx;
      busy_q    <= busy_nx;
      fifo_on_q <= fifo_on;
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));

  assert_full_write_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == cap && wr_stb && !sr_load && !flush) |=> $stable(cnt_q));

  assert_load_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (sr_load && cnt_q != '0 && !busy_q && !flush) |=> busy_q);

  assert_flush_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt_q == '0));
endmodule

// File: rtl/txs_threshold.sv
module txs_threshold
  import uart_txs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] level,
  input  logic [1:0]    thr_sel,
  output logic          at_or_below
);
  logic [CW-1:0] limit;

  always_comb begin
    case (thr_sel_e'(thr_sel))
      THR_EMPTY:   limit = '0;
      THR_TWO:     limit = CW'(2);
      THR_QUARTER: limit = CW'(DEPTH / 4);
      default:     limit = CW'(DEPTH / 2);
    endcase
  end

  assign at_or_below = (level <= limit);
endmodule

// File: rtl/txs_flags.sv
module txs_flags #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_nx,
  input  logic          busy_nx,
  input  logic          fifo_on,
  input  logic          alt_mode,
  input  logic          irq_en,
  input  logic          below,
  output logic          hold_empty,
  output logic          tx_empty,
  output logic          tx_irq
);
  logic prog, prog_q, empty_nx, full_nx, flag_nx;

  assign prog     = alt_mode && fifo_on;
  assign empty_nx = (cnt_nx == '0);
  assign full_nx  = (cnt_nx == CW'(DEPTH));
  assign flag_nx  = prog ? full_nx : empty_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_empty <= 1'b1;
      tx_empty   <= 1'b1;
      tx_irq     <= 1'b0;
      prog_q     <= 1'b0;
    end else begin
      hold_empty <= flag_nx;
      tx_empty   <= empty_nx && !busy_nx;
      tx_irq     <= irq_en && (prog ? below : empty_nx);
      prog_q     <= prog;
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (hold_empty && tx_empty && !tx_irq));

  assert_temt_implies_empty_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_empty && !prog_q) |-> hold_empty);

  assert_full_not_temt_R6: assert property (@(posedge clk) disable iff (rst)
    (prog_q && hold_empty) |-> !tx_empty);

  assert_irq_follows_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_irq && !prog_q) |-> hold_empty);
endmodule

// File: rtl/uart_tx_status.sv
module uart_tx_status #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stb,
  input  logic       sr_load,
  input  logic       sr_done,
  input  logic       fifo_on,
  input  logic       alt_mode,
  input  logic       irq_en,
  input  logic [1:0] thr_sel,
  output logic       hold_empty,
  output logic       tx_empty,
  output logic       tx_irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_nx;
  logic          busy_nx;
  logic          below;

  txs_occupancy #(.DEPTH(DEPTH)) occ_i (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .sr_load (sr_load),
    .sr_done (sr_done),
    .fifo_on (fifo_on),
    .cnt_nx  (cnt_nx),
    .busy_nx (busy_nx)
  );

  txs_threshold #(.DEPTH(DEPTH)) thr_i (
    .level       (cnt_nx),
    .thr_sel     (thr_sel),
    .at_or_below (below)
  );

  txs_flags #(.DEPTH(DEPTH)) flg_i (
    .clk        (clk),
    .rst        (rst),
    .cnt_nx     (cnt_nx),
    .busy_nx    (busy_nx),
    .fifo_on    (fifo_on),
    .alt_mode   (alt_mode),
    .irq_en     (irq_en),
    .below      (below),
    .hold_empty (hold_empty),
    .tx_empty   (tx_empty),
    .tx_irq     (tx_irq)
  );
endmodule

// File: tb/uart_tx_status_tb_top.sv
`timescale 1ns/1ps
module uart_tx_status_tb_top;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_stb = 1'b0, sr_load = 1'b0, sr_done = 1'b0;
  logic fifo_on = 1'b0, alt_mode = 1'b0, irq_en = 1'b0;
  logic [1:0] thr_sel = 2'b00;
  logic hold_empty, tx_empty, tx_irq;

  always #5 clk = ~clk;

  uart_tx_status #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .sr_load(sr_load), .sr_done(sr_done),
    .fifo_on(fifo_on), .alt_mode(alt_mode), .irq_en(irq_en), .thr_sel(thr_sel),
    .hold_empty(hold_empty), .tx_empty(tx_empty), .tx_irq(tx_irq)
  );

  int nchk = 0, nerr = 0;
  bit finished = 0;
  string phase = "R1 reset";

  // cycle model state
  int  m_cnt = 0;
  bit  m_busy = 0, m_fprev = 0;
  logic e_flag = 1, e_temt = 1, e_irq = 0;

  function automatic int limit_of(input logic [1:0] s);
    case (s)
      2'b00: return 0;
      2'b01: return 2;
      2'b10: return DEPTH / 4;
      default: return DEPTH / 2;
    endcase
  endfunction

  task automatic chk(input string what, input logic got, input logic exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL [%s] %s: got %0b expected %0b", phase, what, got, exp);
    end
  endtask

  task automatic step(input logic w, input logic l, input logic d);
    bit flush, wok, lok, prog;
    int cap;
    @(negedge clk);
    wr_stb = w; sr_load = l; sr_done = d;
    if (rst) begin
      m_cnt = 0; m_busy = 0; m_fprev = 0;
      e_flag = 1; e_temt = 1; e_irq = 0;
    end else begin
      flush = (fifo_on != m_fprev);
      cap   = fifo_on ? DEPTH : 1;
      wok   = !flush && w && (m_cnt < cap);
      lok   = !flush && l && (m_cnt != 0) && (!m_busy || d);
      if (flush) m_cnt = 0;
      else m_cnt = m_cnt + int'(wok) - int'(lok);
      m_busy  = lok ? 1 : (d ? 0 : m_busy);
      m_fprev = fifo_on;
      prog    = alt_mode && fifo_on;
      e_flag  = prog ? (m_cnt == DEPTH) : (m_cnt == 0);
      e_temt  = (m_cnt == 0) && !m_busy;
      e_irq   = irq_en && (prog ? (m_cnt <= limit_of(thr_sel)) : (m_cnt == 0));
    end
    @(posedge clk); #1;
    if (rst) begin
      chk("R1 hold_empty", hold_empty, e_flag);
      chk("R1 tx_empty", tx_empty, e_temt);
      chk("R1 tx_irq", tx_irq, e_irq);
    end else begin
      chk((alt_mode && fifo_on) ? "R6 hold_empty" : "R5 hold_empty", hold_empty, e_flag);
      chk("R4 tx_empty", tx_empty, e_temt);
      chk((alt_mode && fifo_on) ? "R8 tx_irq" : "R7 tx_irq", tx_irq, e_irq);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL [watchdog] run did not complete: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    // R1: reset state
    phase = "R1 reset";
    repeat (3) step(0, 0, 0);
    rst = 0;
    irq_en = 1;
    // R2: single holding register, second write ignored
    phase = "R2 holding-full";
    step(1, 0, 0);
    step(1, 0, 0);
    // R3: load into shift register, then completion
    phase = "R3 load/done";
    step(0, 1, 0);
    step(0, 1, 0);     // nothing left to load
    step(1, 0, 0);
    step(0, 1, 0);     // busy, no done: ignored
    step(0, 1, 1);     // done in same cycle: accepted
    step(0, 0, 1);
    // R9: switch FIFO on, write in flush cycle dropped
    phase = "R9 flush";
    fifo_on = 1; alt_mode = 1;
    step(1, 0, 0);
    step(0, 0, 0);
    // R6/R2: fill past full
    phase = "R6 fill to full";
    for (int i = 0; i < DEPTH + 2; i++) step(1, 0, 0);
    // R8: drain one per cycle for each threshold code
    for (int s = 0; s < 4; s++) begin
      phase = "R8 threshold sweep";
      thr_sel = 2'(s);
      for (int i = 0; i < DEPTH + 2; i++) step(0, 1, 1);
      for (int i = 0; i < DEPTH; i++) step(1, 0, 0);
    end
    // R9: switching off flushes a full FIFO
    phase = "R9 flush to holding";
    fifo_on = 0;
    step(0, 0, 0);
    step(0, 0, 1);
    // random mix
    phase = "random R2 R3 R9";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 49) == 0) fifo_on = ~fifo_on;
      if ($urandom_range(0, 29) == 0) alt_mode = ~alt_mode;
      if ($urandom_range(0, 19) == 0) irq_en = ~irq_en;
      if ($urandom_range(0, 9) == 0) thr_sel = 2'($urandom_range(0, 3));
      if (i == 1500) rst = 1;
      if (i == 1502) rst = 0;
      step($urandom_range(0, 99) < 55, $urandom_range(0, 99) < 40,
           $urandom_range(0, 99) < 30);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule